// File: doc/BRIEF.md
# Cascadable Serial Command and Fault Readout Port

This block is the digital serial port of a six-channel low-side gate controller. A host frames each transfer with an active-low chip select. When the select falls, the block freezes the current fault vector into an 8-bit shift register and drives its top bit on the serial output. During the frame, each rising serial clock edge shifts a command bit in at the bottom. Each falling edge presents the next bit on the output. When the select rises, the six most recently shifted bits become the output control register and the serial output is released.

Several devices can share one select and one serial clock in a chain. Command bits that enter a device leave it again behind its own fault word. A chain of N devices therefore exchanges 8·N bits per frame, and the device nearest the host's input returns its fault word first.

Each channel's gate enable is the OR of its serial control bit and a parallel enable input. That parallel path is combinational and uses neither the serial clock nor the select. The serial clock, select, data and fault inputs are asynchronous. They are resynchronized into a faster system clock, and all edge detection runs in that domain. Each serial clock phase must therefore last longer than the synchronizer depth plus one system clock.

Top module: `pdSerialFault`

## Requirements
- R1: The select falling enables the serial output (`sdoOe` high) and drives the captured fault word's MSB, `faultLive[7]`, on `sdoOut` before the first serial clock.
- R2: The fault word bit layout is: bit 7 = over-battery, bit 6 = under-battery, bits 5..0 = load fault of channel 5..0. A 1 means a fault is present. The word leaves MSB first.
- R3: While selected, each serial clock rising edge shifts `sdiIn` into bit 0 of the shift register. Each falling edge puts the register's bit 7 on `sdoOut`, so the remaining seven fault bits follow the MSB in order.
- R4: The select rising copies shift register bits 5..0 into `ctrlReg`. In an 8-bit frame, the 1st and 2nd bits sent are ignored, and the 3rd to 8th bits land on channels 5 down to 0.
- R5: While the select is high, `sdoOe` is low, and serial clock or data activity leaves `ctrlReg` unchanged.
- R6: Fault inputs that change after the select has fallen do not alter the fault word shifted out in that frame.
- R7: In a two-device chain fed by one 16-bit frame, the near device's output is its own fault word, then the far device's fault word, then the host's first bit. The near device latches host bits 3..8, and the far device latches host bits 11..16.
- R8: `gateEn[i]` equals `ctrlReg[i] OR parEn[i]` at all times, with no serial clock or select activity needed.
- R9: A frame of fewer than eight clocks loads `ctrlReg` with whatever the shift register holds, including leftover fault bits.
- R10: After reset, `ctrlReg` is all zero (all channels off) and `sdoOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock, asynchronous |
| sdiIn | input | 1 | Serial command data in |
| csIn | input | 1 | Active-low frame select |
| faultLive | input | 8 | Live fault vector (R2 layout) |
| parEn | input | 6 | Parallel per-channel enables |
| sdoOut | output | 1 | Serial data out value |
| sdoOe | output | 1 | Serial output drive enable (high-Z when low) |
| ctrlReg | output | 6 | Output control register |
| gateEn | output | 6 | Per-channel gate enables |

## Verification
Two functions can act on the same channel in the same cycle: the serial latch at the select's rising edge, and the parallel OR path. The bench holds a parallel enable high on a channel throughout a frame whose command turns that same channel off. Once the latch has taken effect, it expects `ctrlReg` to show the channel off and `gateEn` to keep it on. It then drops the parallel input and checks that the gate follows the register. The chained pair is also checked as the near device's serial output streams the far device's word out behind its own.

// File: rtl/pd_pkg.sv
package pd_pkg;
  // strobes from control to datapath, each one system clock wide
  typedef struct packed {
    logic capture;  // freeze fault vector into shift register
    logic shift;    // take one command bit in at the bottom
    logic emit;     // present next bit on the serial output
    logic latch;    // copy low bits into control register
  } pdStrobe_t;
endpackage

// File: rtl/pdSync.sv
module pdSync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL[i]}};
      else        pipe <= {pipe[STAGES-2:0], din[i]};
    end
    assign dout[i] = pipe[STAGES-1];
  end
endmodule

// File: rtl/pdCtrl.sv
module pdCtrl
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      csS,
  input  logic      sclkS,
  output pdStrobe_t strobe,
  output logic      sdoOe
);
  typedef enum logic {IDLE, FRAME} pdState_e;
  pdState_e state;
  logic csQ, sclkQ;
  logic csFall, csRise, sclkRise, sclkFall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csQ   <= 1'b1;
      sclkQ <= 1'b0;
    end else begin
      csQ   <= csS;
      sclkQ <= sclkS;
    end
  end

  assign csFall   = csQ & ~csS;
  assign csRise   = ~csQ & csS;
  assign sclkRise = ~sclkQ & sclkS;
  assign sclkFall = sclkQ & ~sclkS;

  always_comb begin
    strobe.capture = csFall;
    strobe.latch   = csRise && state == FRAME;
    strobe.shift   = state == FRAME && !csS && sclkRise;
    strobe.emit    = state == FRAME && !csS && sclkFall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              state <= IDLE;
    else if (strobe.capture) state <= FRAME;
    else if (strobe.latch)   state <= IDLE;
  end

  assign sdoOe = state == FRAME;
endmodule

// File: rtl/pdPath.sv
module pdPath
  import pd_pkg::*;
#(
  parameter int CH = 6,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pdStrobe_t     strobe,
  input  logic          sdiS,
  input  logic [FW-1:0] faultS,
  input  logic [CH-1:0] parEn,
  output logic          sdoBit,
  output logic [FW-1:0] shiftView,
  output logic [CH-1:0] ctrlReg,
  output logic [CH-1:0] gateEn
);
  logic [FW-1:0] shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      sdoBit   <= 1'b0;
    end else if (strobe.capture) begin
      shiftReg <= faultS;
      sdoBit   <= faultS[FW-1];
    end else begin
      if (strobe.shift) shiftReg <= {shiftReg[FW-2:0], sdiS};
      if (strobe.emit)  sdoBit   <= shiftReg[FW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctrlReg <= '0;
    else if (strobe.latch) ctrlReg <= shiftReg[CH-1:0];
  end

  // parallel path stays combinational, no clock needed
  assign gateEn    = ctrlReg | parEn;
  assign shiftView = shiftReg;
endmodule

// File: rtl/pdSerialFault.sv
module pdSerialFault
  import pd_pkg::*;
#(
  parameter int CH = 6,
  parameter int FW = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclkIn,
  input  logic          sdiIn,
  input  logic          csIn,
  input  logic [FW-1:0] faultLive,
  input  logic [CH-1:0] parEn,
  output logic          sdoOut,
  output logic          sdoOe,
  output logic [CH-1:0] ctrlReg,
  output logic [CH-1:0] gateEn
);
  logic          csS, sclkS, sdiS;
  logic [FW-1:0] faultS;
  logic [FW-1:0] shiftView;
  pdStrobe_t     strobe;

  pdSync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) syncCtl_i (
    .clk(clk), .rst_n(rst_n),
    .din({csIn, sclkIn, sdiIn}), .dout({csS, sclkS, sdiS})
  );

  pdSync #(.W(FW), .STAGES(SYNC), .RST_VAL('0)) syncFlt_i (
    .clk(clk), .rst_n(rst_n), .din(faultLive), .dout(faultS)
  );

  pdCtrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .csS(csS), .sclkS(sclkS),
    .strobe(strobe), .sdoOe(sdoOe)
  );

  pdPath #(.CH(CH), .FW(FW)) path_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sdiS(sdiS),
    .faultS(faultS), .parEn(parEn), .sdoBit(sdoOut),
    .shiftView(shiftView), .ctrlReg(ctrlReg), .gateEn(gateEn)
  );
endmodule

// File: rtl/pdSerialFault_chk.sv
module pdSerialFault_chk #(
  parameter int CH = 6,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csS,
  input logic          sclkS,
  input logic          sdiS,
  input logic [FW-1:0] faultS,
  input logic [FW-1:0] shiftView,
  input logic          sdoOut,
  input logic          sdoOe,
  input logic [CH-1:0] ctrlReg,
  input logic [CH-1:0] parEn,
  input logic [CH-1:0] gateEn
);
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csS) |=> sdoOe && sdoOut == $past(faultS[FW-1]));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csS) |=> !sdoOe);

  p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csS) |=> ctrlReg == $past(shiftView[CH-1:0]));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(csS) |=> $stable(ctrlReg));

  p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdoOe && !csS && $rose(sclkS)) |=> shiftView[0] == $past(sdiS));

  p_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdoOe && !csS && $fell(sclkS)) |=> sdoOut == $past(shiftView[FW-1]));

  p_gate_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlReg & ~gateEn) == '0 && (parEn & ~gateEn) == '0);
endmodule

bind pdSerialFault pdSerialFault_chk #(.CH(CH), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .csS(csS), .sclkS(sclkS), .sdiS(sdiS),
  .faultS(faultS), .shiftView(shiftView), .sdoOut(sdoOut), .sdoOe(sdoOe),
  .ctrlReg(ctrlReg), .parEn(parEn), .gateEn(gateEn)
);

// File: tb/pdSerialFault_tb_top.sv
module pdSerialFault_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs = 1'b1;
  logic [7:0] faultDut = '0, faultFar = '0, faultNear = '0;
  logic [5:0] parDut = '0;
  logic sdoDut, oeDut, sdoFar, oeFar, sdoNear, oeNear;
  logic [5:0] ctrlDut, gateDut, ctrlFar, gateFar, ctrlNear, gateNear;
  logic farToNear;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic expQ[$];
  string tagQ[$];
  event sampleEv;
  logic chainSeen[33];
  logic chainOe[33];

  always #(CLK_PERIOD/2) clk = ~clk;

  pdSerialFault dut_i (
    .clk(clk), .rst_n(rst_n), .sclkIn(sclk), .sdiIn(sdi), .csIn(cs),
    .faultLive(faultDut), .parEn(parDut), .sdoOut(sdoDut), .sdoOe(oeDut),
    .ctrlReg(ctrlDut), .gateEn(gateDut));

  pdSerialFault farDev_i (
    .clk(clk), .rst_n(rst_n), .sclkIn(sclk), .sdiIn(sdi), .csIn(cs),
    .faultLive(faultFar), .parEn(6'b0), .sdoOut(sdoFar), .sdoOe(oeFar),
    .ctrlReg(ctrlFar), .gateEn(gateFar));

  assign farToNear = oeFar ? sdoFar : 1'b0;

  pdSerialFault nearDev_i (
    .clk(clk), .rst_n(rst_n), .sclkIn(sclk), .sdiIn(farToNear), .csIn(cs),
    .faultLive(faultNear), .parEn(6'b0), .sdoOut(sdoNear), .sdoOe(oeNear),
    .ctrlReg(ctrlNear), .gateEn(gateNear));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected serial bits as the driver announces samples
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() > 0) begin
        logic e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " sdo bit"}, {31'b0, sdoDut}, {31'b0, e});
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushSample(input logic e, input string t, input int idx);
    expQ.push_back(e);
    tagQ.push_back(t);
    chainSeen[idx] = sdoNear;
    chainOe[idx] = oeNear;
    ->sampleEv;
    #1;
  endtask

  // drives one frame of n clocks; bits[n-1] goes first
  task automatic frame(input int n, input logic [31:0] bits, input logic [7:0] fStart,
                       input logic [7:0] fMid, input string tag);
    logic [7:0] mdl;
    mdl = fStart;
    faultDut = fStart;
    waitClk(HALF);
    cs = 1'b0;
    waitClk(HALF);
    chk({tag, " R1 oe at select"}, {31'b0, oeDut}, 32'd1);
    pushSample(mdl[7], tag, 0);
    faultDut = fMid;
    for (int k = 0; k < n; k++) begin
      sdi = bits[n-1-k];
      waitClk(HALF);
      sclk = 1'b1;
      mdl = {mdl[6:0], bits[n-1-k]};
      waitClk(HALF);
      sclk = 1'b0;
      waitClk(HALF);
      pushSample(mdl[7], tag, k + 1);
    end
    cs = 1'b1;
    waitClk(HALF);
    chk({tag, " ctrl model"}, {26'b0, ctrlDut}, {26'b0, mdl[5:0]});
    chk({tag, " R5 oe released"}, {31'b0, oeDut}, 32'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    waitClk(4);
    rst_n = 1'b1;
    waitClk(4);
    // R10 reset state
    chk("R10 ctrl reset", {26'b0, ctrlDut}, 32'd0);
    chk("R10 oe reset", {31'b0, oeDut}, 32'd0);
    chk("R10 gate reset", {26'b0, gateDut}, 32'd0);

    // R1 R2 R3 R4: full frame; 3rd..8th bits 101001 go to ch5..ch0
    frame(8, 32'h69, 8'hA5, 8'hA5, "R4");
    chk("R4 ctrl literal", {26'b0, ctrlDut}, 32'h29);

    // R2: only over-battery set -> first bit 1, the rest 0
    frame(8, 32'h00, 8'h80, 8'h80, "R2");
    // R2: under-battery and channel 0 load fault
    frame(8, 32'hFF, 8'b0100_0001, 8'b0100_0001, "R2");
    chk("R2 ctrl all on", {26'b0, ctrlDut}, 32'h3F);

    // R6: faults change after select falls; old word still shifted out
    frame(8, 32'h3C, 8'h0F, 8'hF0, "R6");

    // R5: activity with select high is ignored
    sdi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      waitClk(HALF); sclk = 1'b1; waitClk(HALF); sclk = 1'b0;
    end
    waitClk(HALF);
    chk("R5 ctrl unchanged", {26'b0, ctrlDut}, 32'h3C);
    chk("R5 oe low", {31'b0, oeDut}, 32'd0);

    // R9: 5-clock frame keeps leftover fault bit: ctrl = 1,1,0,1,1,0 -> 110110
    frame(5, 32'b10110, 8'hC3, 8'hC3, "R9");
    chk("R9 ctrl literal", {26'b0, ctrlDut}, 32'h36);

    // R8: parallel held on ch5 while serial turns it off
    parDut = 6'b100000;
    #1;
    chk("R8 gate or before", {26'b0, gateDut}, 32'h36 | 32'h20);
    frame(8, 32'h05, 8'h00, 8'h00, "R8");
    chk("R8 ctrl off ch5", {26'b0, ctrlDut}, 32'h05);
    chk("R8 gate kept", {26'b0, gateDut}, 32'h25);
    parDut = 6'b000000;
    #1;
    chk("R8 gate follows ctrl", {26'b0, gateDut}, 32'h05);

    // R7: chain of two, 16 host bits c1..c16 = B3 7E
    faultFar = 8'h5A;
    faultNear = 8'hC6;
    frame(16, 32'hB37E, 8'h11, 8'h11, "R7");
    for (int k = 0; k < 17; k++) begin
      logic e;
      if (k < 8)       e = faultNear[7-k];
      else if (k < 16) e = faultFar[15-k];
      else             e = 1'b1;
      chk($sformatf("R7 chain bit %0d", k), {31'b0, chainSeen[k]}, {31'b0, e});
    end
    chk("R7 near oe", {31'b0, chainOe[3]}, 32'd1);
    chk("R7 near ctrl", {26'b0, ctrlNear}, 32'h33);
    chk("R7 far ctrl", {26'b0, ctrlFar}, 32'h3E);

    waitClk(4);
    chk("R3 queue drained", expQ.size(), 32'd0);
    finishRun();
  end
endmodule